// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates one 32-bit virtual address at a time by walking a tree of translation tables held in external memory. A walk starts from a context table base and a 4-bit context number. It then reads one descriptor at each of four levels: context, region, segment and page. Each descriptor either points to the next table or ends the walk. The final page entry goes through a user/supervisor permission check, and then its usage bits are updated in memory.

The block talks to memory through a word-wide port that carries one request at a time. A walk ends with a single-cycle completion pulse. The pulse carries either a physical address with a cacheable flag, or a fault with the level where the walk stopped and the reason. Translation caching sits outside this block.

Top module: `ptw_top`

## Requirements
- R1: The entry read at level 0 is at `ctx_table_base + ctx*4`. At levels 1, 2 and 3 the entry is read at `table_base + idx*4`, where idx is vaddr[31:24], vaddr[23:18] and vaddr[17:12] respectively.
- R2: The two low bits of an entry give its kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. An invalid entry faults with type 1, and a reserved entry faults with type 2.
- R3: The base of the next table is the pointer entry with bits 1:0 cleared, shifted left by 4 into a 36-bit byte address.
- R4: A leaf found at levels 0 to 2, or a pointer found at level 3, faults with type 3 and is not followed.
- R5: The leaf access code in bits 4:2 grants user/supervisor rights as follows: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. Access kinds are encoded 0 load (needs R), 1 store (needs W) and 2 fetch (needs X). A denied access faults with type 4 at level 3, so any user access with a code above 5 faults.
- R6: On success, done_paddr = {leaf[31:8], vaddr[11:0]}, done_cacheable = leaf bit 7, done_fault = 0, done_ftype = 0 and done_level = 3.
- R7: After a successful check, the leaf is written back to the address it was read from with bit 5 (referenced) set, and with bit 6 (modified) also set on a store.
- R8: The write-back happens only when it changes the entry. A faulting walk writes nothing.
- R9: A fault reports done_fault = 1, the level 0 to 3 of the entry that stopped the walk, and a nonzero done_ftype.
- R10: At most one memory request is outstanding. A new request is issued only after the response to the previous one.
- R11: done_valid lasts exactly one cycle, and busy drops on the following cycle. walk_start is ignored while busy.
- R12: After reset, busy, done_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_start | input | 1 | Start a walk (taken when idle) |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_ctx | input | 4 | Context number |
| walk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| walk_user | input | 1 | 1 for user mode, 0 for supervisor |
| ctx_table_base | input | 36 | Byte address of the context table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request strobe (one cycle) |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Response strobe (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Walk result pulse |
| done_fault | output | 1 | Walk faulted |
| done_level | output | 2 | Level at which the walk ended |
| done_ftype | output | 3 | 0 none, 1 invalid, 2 reserved, 3 wrong level, 4 protection |
| done_paddr | output | 36 | Physical address |
| done_cacheable | output | 1 | Cacheable flag of the page |

## Verification
The checker makes three assumptions about the inputs. The memory returns exactly one response per request and never an unsolicited one. ctx_table_base is word aligned and held steady. Pointer entries therefore always produce aligned table bases. The bench memory model answers each request once, after a latency of 1 to 3 cycles. The bench keeps a fixed aligned context base and builds every table at aligned locations, so the alignment and single-outstanding properties hold under all of its stimulus.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ENT_INVALID = 2'd0,
    ENT_PTR     = 2'd1,
    ENT_LEAF    = 2'd2,
    ENT_RSVD    = 2'd3
  } ent_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_RSVD    = 3'd2,
    FLT_LEVEL   = 3'd3,
    FLT_PROT    = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_WWAIT, ST_DONE
  } walk_st_e;

  localparam int BIT_CACHE = 7;
  localparam int BIT_MOD   = 6;
  localparam int BIT_REF   = 5;
  localparam int CODE_LO   = 2;

  // Returns {read, write, execute} rights for an access code and mode.
  function automatic logic [2:0] code_rights(input logic [2:0] code, input logic user);
    case (code)
      3'd0:    code_rights = 3'b100;
      3'd1:    code_rights = 3'b110;
      3'd2:    code_rights = 3'b101;
      3'd3:    code_rights = 3'b111;
      3'd4:    code_rights = 3'b001;
      3'd5:    code_rights = user ? 3'b100 : 3'b110;
      3'd6:    code_rights = user ? 3'b000 : 3'b101;
      default: code_rights = user ? 3'b000 : 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 4,
  parameter int REG_W = 8,
  parameter int SEG_W = 6,
  parameter int PG_W  = 6,
  parameter int OFF_W = 12
) (
  input  logic [1:0]                          level,
  input  logic [CTX_W-1:0]                    ctx,
  input  logic [REG_W+SEG_W+PG_W+OFF_W-1:0]   vaddr,
  input  logic [PA_W-1:0]                     ctx_base,
  input  logic [PA_W-1:0]                     tbase,
  output logic [PA_W-1:0]                     addr
);
  localparam int VA_W   = REG_W + SEG_W + PG_W + OFF_W;
  localparam int PG_LO  = OFF_W;
  localparam int SEG_LO = PG_LO + PG_W;
  localparam int REG_LO = SEG_LO + SEG_W;

  logic [PA_W-1:0] base;
  logic [PA_W-1:0] idx;

  always_comb begin
    base = tbase;
    case (level)
      2'd0: begin base = ctx_base; idx = PA_W'(ctx); end
      2'd1: idx = PA_W'(vaddr[VA_W-1:REG_LO]);
      2'd2: idx = PA_W'(vaddr[REG_LO-1:SEG_LO]);
      default: idx = PA_W'(vaddr[SEG_LO-1:PG_LO]);
    endcase
    addr = base + (idx << 2);
  end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       level,
  input  acc_e             acc,
  input  logic             user,
  output logic             descend,
  output logic             leaf_ok,
  output flt_e             flt,
  output logic [ENT_W-1:0] upd_entry,
  output logic             upd_needed
);
  ent_kind_e  kind;
  logic [2:0] rwx;
  logic       allowed;
  logic       last;

  assign kind = ent_kind_e'(entry[1:0]);
  assign last = (level == 2'd3);
  assign rwx  = code_rights(entry[CODE_LO+2:CODE_LO], user);

  always_comb begin
    case (acc)
      ACC_LOAD:  allowed = rwx[2];
      ACC_STORE: allowed = rwx[1];
      ACC_FETCH: allowed = rwx[0];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    descend = 1'b0;
    leaf_ok = 1'b0;
    flt     = FLT_NONE;
    case (kind)
      ENT_INVALID: flt = FLT_INVALID;
      ENT_RSVD:    flt = FLT_RSVD;
      ENT_PTR: begin
        if (last) flt = FLT_LEVEL;
        else      descend = 1'b1;
      end
      default: begin
        if (!last)         flt = FLT_LEVEL;
        else if (!allowed) flt = FLT_PROT;
        else               leaf_ok = 1'b1;
      end
    endcase
  end

  always_comb begin
    upd_entry = entry;
    upd_entry[BIT_REF] = 1'b1;
    if (acc == ACC_STORE) upd_entry[BIT_MOD] = 1'b1;
    upd_needed = (upd_entry != entry);
  end
endmodule

// File: rtl/ptw_top.sv
// Reset is asserted asynchronously; its release is expected to be
// synchronised to clk outside this block.
module ptw_top
  import ptw_pkg::*;
#(
  parameter int CTX_W = 4,
  parameter int REG_W = 8,
  parameter int SEG_W = 6,
  parameter int PG_W  = 6,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32,
  localparam int VA_W = REG_W + SEG_W + PG_W + OFF_W,
  localparam int PA_W = ENT_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [VA_W-1:0]   walk_vaddr,
  input  logic [CTX_W-1:0]  walk_ctx,
  input  logic [1:0]        walk_acc,
  input  logic              walk_user,
  input  logic [PA_W-1:0]   ctx_table_base,
  output logic              busy,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [ENT_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_rdata,
  output logic              done_valid,
  output logic              done_fault,
  output logic [1:0]        done_level,
  output logic [2:0]        done_ftype,
  output logic [PA_W-1:0]   done_paddr,
  output logic              done_cacheable
);
  localparam int PPN_LO = 8;
  localparam int PPN_W  = ENT_W - PPN_LO;

  walk_st_e         state_q, state_d;
  logic [1:0]       level_q;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PA_W-1:0]  tbase_q;
  logic [PA_W-1:0]  addr_q;
  logic [ENT_W-1:0] wdata_q;
  logic             res_fault_q, res_cache_q;
  logic [1:0]       res_level_q;
  logic [2:0]       res_ftype_q;
  logic [PA_W-1:0]  res_paddr_q;

  logic [PA_W-1:0]  gen_addr;
  logic             descend, leaf_ok, upd_needed;
  flt_e             flt;
  logic [ENT_W-1:0] upd_entry;

  logic cap_en, rd_en, step_en, res_en;

  ptw_addr_gen #(
    .PA_W(PA_W), .CTX_W(CTX_W), .REG_W(REG_W),
    .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)
  ) u_addr (
    .level(level_q), .ctx(ctx_q), .vaddr(va_q),
    .ctx_base(ctx_table_base), .tbase(tbase_q), .addr(gen_addr)
  );

  ptw_entry_eval #(.ENT_W(ENT_W)) u_eval (
    .entry(mem_rsp_rdata), .level(level_q), .acc(acc_q), .user(user_q),
    .descend(descend), .leaf_ok(leaf_ok), .flt(flt),
    .upd_entry(upd_entry), .upd_needed(upd_needed)
  );

  // Next-state and enables
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    rd_en   = 1'b0;
    step_en = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (walk_start) begin cap_en = 1'b1; state_d = ST_RD; end
      ST_RD: begin rd_en = 1'b1; state_d = ST_RWAIT; end
      ST_RWAIT: if (mem_rsp_valid) begin
        if (descend) begin
          step_en = 1'b1;
          state_d = ST_RD;
        end else begin
          res_en  = 1'b1;
          state_d = (leaf_ok && upd_needed) ? ST_WR : ST_DONE;
        end
      end
      ST_WR:    state_d = ST_WWAIT;
      ST_WWAIT: if (mem_rsp_valid) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      level_q     <= '0;
      va_q        <= '0;
      ctx_q       <= '0;
      acc_q       <= ACC_LOAD;
      user_q      <= 1'b0;
      tbase_q     <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      res_fault_q <= 1'b0;
      res_cache_q <= 1'b0;
      res_level_q <= '0;
      res_ftype_q <= '0;
      res_paddr_q <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        va_q    <= walk_vaddr;
        ctx_q   <= walk_ctx;
        acc_q   <= acc_e'(walk_acc);
        user_q  <= walk_user;
        level_q <= '0;
      end
      if (rd_en) addr_q <= gen_addr;
      if (step_en) begin
        tbase_q <= PA_W'({mem_rsp_rdata[ENT_W-1:2], 2'b00}) << 4;
        level_q <= level_q + 2'd1;
      end
      if (res_en) begin
        res_fault_q <= (flt != FLT_NONE);
        res_ftype_q <= flt;
        res_level_q <= level_q;
        res_cache_q <= leaf_ok & mem_rsp_rdata[BIT_CACHE];
        res_paddr_q <= leaf_ok ?
          PA_W'({mem_rsp_rdata[ENT_W-1:PPN_LO], va_q[OFF_W-1:0]}) : '0;
        wdata_q     <= upd_entry;
      end
    end
  end

  assign busy           = (state_q != ST_IDLE);
  assign mem_req_valid  = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_we     = (state_q == ST_WR);
  assign mem_req_addr   = (state_q == ST_WR) ? addr_q : gen_addr;
  assign mem_req_wdata  = wdata_q;
  assign done_valid     = (state_q == ST_DONE);
  assign done_fault     = res_fault_q;
  assign done_level     = res_level_q;
  assign done_ftype     = res_ftype_q;
  assign done_paddr     = res_paddr_q;
  assign done_cacheable = res_cache_q;

  logic unused_ok;
  assign unused_ok = &{1'b0, PPN_W[0]};
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk #(
  parameter int PA_W  = 36,
  parameter int ENT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_we,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [ENT_W-1:0] mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             done_valid,
  input logic             done_fault,
  input logic [1:0]       done_level,
  input logic [2:0]       done_ftype
);
  logic            outst;
  logic [PA_W-1:0] last_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst   <= 1'b0;
      last_rd <= '0;
    end else begin
      if (mem_req_valid)      outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
      if (mem_req_valid && !mem_req_we) last_rd <= mem_req_addr;
    end
  end

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst);
  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  a_r7_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_addr == last_rd));
  a_r7_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[5]);
  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !busy);
  a_r6_success_report: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_level == 2'd3 && done_ftype == 3'd0));
  a_r9_fault_has_type: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_ftype != 3'd0));
endmodule

bind ptw_top ptw_top_chk #(.PA_W(PA_W), .ENT_W(ENT_W)) u_chk (.*);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        walk_start;
  logic [31:0] walk_vaddr;
  logic [3:0]  walk_ctx;
  logic [1:0]  walk_acc;
  logic        walk_user;
  logic [35:0] ctx_table_base;
  logic        busy, mem_req_valid, mem_req_we;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done_valid, done_fault, done_cacheable;
  logic [1:0]  done_level;
  logic [2:0]  done_ftype;
  logic [35:0] done_paddr;

  always #2 clk = ~clk;

  ptw_top u0 (.*);

  // Memory model: 16 KiB, variable latency, one response per request.
  logic [31:0] mem [0:4095];
  logic        pend = 1'b0;
  int          cnt = 0;
  int          lat = 1;
  int          rd_n = 0, wr_n = 0;
  logic [35:0] rd_log [0:3];
  int          total = 0, bad = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin mem_rsp_valid <= 1'b1; pend <= 1'b0; end
      else cnt <= cnt - 1;
    end
    if (mem_req_valid) begin
      pend <= 1'b1;
      cnt  <= lat - 1;
      if (mem_req_we) begin
        mem[mem_req_addr[13:2]] = mem_req_wdata;
        wr_n = wr_n + 1;
      end else begin
        mem_rsp_rdata <= mem[mem_req_addr[13:2]];
        if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
        rd_n = rd_n + 1;
      end
    end
  end

  localparam logic [35:0] CTXB = 36'h100;
  localparam logic [35:0] RGB  = 36'h400;
  localparam logic [35:0] SGB  = 36'h800;
  localparam logic [35:0] PGB  = 36'hC00;
  // Pointer entries for the tables above: (base >> 4) | 1
  localparam logic [31:0] P_RG = 32'h41;
  localparam logic [31:0] P_SG = 32'h81;
  localparam logic [31:0] P_PG = 32'hC1;

  // Rights per code, bit i = code i
  localparam logic [7:0] U_R = 8'h2F, U_W = 8'h0A, U_X = 8'h1C;
  localparam logic [7:0] S_R = 8'hEF, S_W = 8'hAA, S_X = 8'hDC;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
  endtask

  task automatic put(input logic [35:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [3:0] ctx,
                         input logic [1:0] acc, input bit usr, input bit poke);
    @(negedge clk);
    rd_n = 0; wr_n = 0;
    walk_vaddr = va; walk_ctx = ctx; walk_acc = acc; walk_user = usr;
    walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
    if (poke) begin
      walk_start = 1'b1; walk_vaddr = ~va; walk_ctx = ~ctx;
      @(negedge clk);
      walk_start = 1'b0; walk_vaddr = va; walk_ctx = ctx;
    end
    while (!done_valid) @(negedge clk);
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] lvl, input logic [2:0] ft);
    chk(done_fault == 1'b1, {tag, " fault flag"}, done_fault, 1);
    chk(done_level == lvl, {tag, " level"}, done_level, lvl);
    chk(done_ftype == ft, {tag, " type"}, done_ftype, ft);
    chk(wr_n == 0, {tag, " R8 no write on fault"}, wr_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; walk_start = 1'b0; walk_vaddr = '0; walk_ctx = '0;
    walk_acc = '0; walk_user = 1'b0; ctx_table_base = CTXB;
    clear_mem();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy, "R12 busy after reset", busy, 0);
    chk(!done_valid, "R12 done_valid after reset", done_valid, 0);
    chk(!mem_req_valid, "R12 mem_req_valid after reset", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep: every code x mode x access kind x initial usage bits
    for (int code = 0; code < 8; code++)
      for (int usr = 0; usr < 2; usr++)
        for (int acc = 0; acc < 3; acc++)
          for (int rm = 0; rm < 4; rm++) begin
            int idx;
            logic [7:0]  rgi;
            logic [5:0]  sgi, pgi;
            logic [11:0] off;
            logic [3:0]  ctx;
            logic [23:0] ppn;
            logic [31:0] va, pte, fin;
            logic        cb, ok;
            logic [7:0]  rmask;
            idx = ((code * 2 + usr) * 3 + acc) * 4 + rm;
            rgi = 8'(idx * 7); sgi = 6'(idx * 5); pgi = 6'(idx * 3 + 1);
            off = 12'(idx * 289); ctx = 4'(idx);
            ppn = 24'h5A0000 ^ 24'(idx * 24'h1357);
            cb  = idx[0] ^ idx[3];
            va  = {rgi, sgi, pgi, off};
            pte = {ppn, cb, rm[1], rm[0], 3'(code), 2'b10};
            lat = 1 + (idx % 3);
            clear_mem();
            put(CTXB + 36'(ctx) * 4, P_RG);
            put(RGB + 36'(rgi) * 4, P_SG);
            put(SGB + 36'(sgi) * 4, P_PG);
            put(PGB + 36'(pgi) * 4, pte);
            do_walk(va, ctx, 2'(acc), usr[0], 1'b0);
            rmask = (acc == 0) ? (usr ? U_R : S_R) : (acc == 1) ? (usr ? U_W : S_W) : (usr ? U_X : S_X);
            ok = rmask[code];
            // R1/R3: addresses of the four reads
            chk(rd_log[0] == CTXB + 36'(ctx) * 4, "R1 ctx entry addr", rd_log[0], CTXB + 36'(ctx) * 4);
            chk(rd_log[1] == RGB + 36'(rgi) * 4, "R3 region entry addr", rd_log[1], RGB + 36'(rgi) * 4);
            chk(rd_log[2] == SGB + 36'(sgi) * 4, "R3 segment entry addr", rd_log[2], SGB + 36'(sgi) * 4);
            chk(rd_log[3] == PGB + 36'(pgi) * 4, "R1 page entry addr", rd_log[3], PGB + 36'(pgi) * 4);
            if (ok) begin
              fin = pte | 32'h20 | ((acc == 1) ? 32'h40 : 32'h0);
              chk(done_fault == 1'b0, "R5 allowed access", done_fault, 0);
              chk(done_paddr == {ppn, off}, "R6 paddr", done_paddr, {ppn, off});
              chk(done_cacheable == cb, "R6 cacheable", done_cacheable, cb);
              chk(mem[pgi + 12'h300] == fin, "R7 updated entry", mem[pgi + 12'h300], fin);
              chk(wr_n == ((fin != pte) ? 1 : 0), "R8 write-back count", wr_n, (fin != pte) ? 1 : 0);
            end else begin
              expect_fault("R5 denied access", 2'd3, 3'd4);
              chk(mem[pgi + 12'h300] == pte, "R8 entry unchanged", mem[pgi + 12'h300], pte);
            end
            @(negedge clk);
            chk(!busy, "R11 idle after done", busy, 0);
          end

    // Directed faults
    lat = 2;
    clear_mem();
    do_walk(32'h12345678, 4'd3, 2'd0, 1'b0, 1'b0);
    expect_fault("R2 R9 invalid ctx entry", 2'd0, 3'd1);

    clear_mem();
    put(CTXB + 4 * 5, P_RG); put(RGB + 4 * 8'hAB, 32'h0000_0043);
    do_walk(32'hAB00_0000, 4'd5, 2'd0, 1'b0, 1'b0);
    expect_fault("R2 reserved region entry", 2'd1, 3'd2);

    clear_mem();
    put(CTXB + 4 * 5, P_RG); put(RGB + 4 * 8'hAB, 32'h1234_56EE);
    do_walk(32'hAB00_0000, 4'd5, 2'd0, 1'b0, 1'b0);
    expect_fault("R4 early leaf", 2'd1, 3'd3);

    clear_mem();
    put(CTXB + 4 * 2, P_RG); put(RGB + 4 * 8'h10, P_SG);
    do_walk(32'h10C0_0000, 4'd2, 2'd1, 1'b1, 1'b0);
    expect_fault("R9 invalid segment entry", 2'd2, 3'd1);

    clear_mem();
    put(CTXB, P_RG); put(RGB, P_SG); put(SGB, P_PG); put(PGB, P_PG);
    do_walk(32'h0000_0ABC, 4'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R4 pointer at page level", 2'd3, 3'd3);

    // R11: start request while busy is ignored
    clear_mem();
    put(CTXB + 4 * 7, P_RG); put(RGB + 4 * 8'h3C, P_SG);
    put(SGB + 4 * 6'h2A, P_PG); put(PGB + 4 * 6'h15, 32'hBEEF_01AE);
    do_walk({8'h3C, 6'h2A, 6'h15, 12'h321}, 4'd7, 2'd0, 1'b0, 1'b1);
    chk(!done_fault && done_paddr == 36'hBEEF01321, "R11 start ignored while busy",
        done_paddr, 36'hBEEF01321);
    chk(rd_n == 4, "R11 single walk reads", rd_n, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule